// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a processor and its memory system and turns 32-bit virtual addresses into physical addresses, with 4 KiB pages. Each request carries a virtual address, a write flag and a user/supervisor flag. In the same cycle the block returns either a physical address with a cacheability attribute or a fault with one of three causes. It keeps recent page entries in a small, fully associative translation cache. On a miss it stalls the requester, fetches the entry from a single-level page table in memory and fills it into the cache. It then completes the stalled request from the cache.

The requester holds its request steady while `stall` is high. The table base is loaded through a configuration write. A one-cycle `flush` pulse empties the cache, and software issues one after changing the base. When a virtually indexed first-level cache has already hit, the requester raises `xlateSkip`. The block still checks permissions and still reports faults and cacheability, but it drives no physical address.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, `stall`, `respValid`, `respFault` and `memReqValid` are low.
- R2: On a successful access, `respPaddr` is the cached physical page number (table entry bits 31:12) joined to the unchanged low 12 bits of the virtual address.
- R3: On a cache miss, `stall` is high until the request completes. `memReqValid` is held with `memReqAddr` = base + virtual page number × 4 until `memRespValid`. A later access to the same page completes without a table fetch.
- R4: `respCacheable` equals entry bit 3 on a non-faulting access. It is 0 for pages marked volatile (bit 3 clear).
- R5: An entry with the present bit (bit 0) clear gives `respFault`=1 with `respCause`=1 (unmapped), and `respPaddr`=0.
- R6: A user access (`reqUser`=1) to an entry with the user bit (bit 2) clear faults with `respCause`=2 (privilege). A supervisor access to the same page does not fault.
- R7: A write to an entry with the writable bit (bit 1) clear faults with `respCause`=3 (illegal operation). A read of the same page succeeds.
- R8: When several causes hold, unmapped wins over privilege, and privilege wins over illegal operation.
- R9: With `xlateSkip`=1, `respPaddr` is 0, while fault, cause and cacheability are reported as without it.
- R10: Refills go to the cache slots in round-robin order from slot 0. The ninth distinct page evicts the first one filled, and the other seven stay cached.
- R11: A `flush` pulse invalidates every cached entry, so the next access to any page fetches from the table.
- R12: A `flush` that arrives while a fetch is outstanding discards that fetched entry. The request is then fetched again, using the base register as it stands at that point.
- R13: Entries that fault are still cached, so a repeated faulting access causes no new table fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqUser | input | 1 | 1 = user privilege, 0 = supervisor |
| xlateSkip | input | 1 | Address not needed; suppress `respPaddr` only |
| respValid | output | 1 | Access completed this cycle |
| respPaddr | output | 32 | Physical address |
| respCacheable | output | 1 | Page may be cached |
| respFault | output | 1 | Access rejected |
| respCause | output | 2 | 1 unmapped, 2 privilege, 3 illegal operation |
| stall | output | 1 | Requester must hold its request |
| memReqValid | output | 1 | Table entry fetch request |
| memReqAddr | output | 32 | Address of table entry |
| memRespValid | input | 1 | Fetched entry available |
| memRespData | input | 32 | Fetched table entry |
| cfgWrEn | input | 1 | Write table base |
| cfgWrData | input | 32 | New table base |
| flush | input | 1 | Invalidate all cached entries |

## Verification
Two events can fall in the same fetch window: the refill of the cache and a flush. The bench raises `flush` together with a base change two cycles into a fetch, while the memory model is still counting down its latency. The design is judged correct if exactly two fetches complete for the one request, the second at the address built from the new base, and the request then finishes with the entry's physical address.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_UNMAPPED = 2'd1,
    CAUSE_PRIV     = 2'd2,
    CAUSE_ILLEGAL  = 2'd3
  } causeT;

  typedef struct packed {
    logic startWalk;
    logic fillEn;
    logic flushAll;
  } ctrlStrobeT;

  localparam int PTE_PRESENT = 0;
  localparam int PTE_WRITE   = 1;
  localparam int PTE_USER    = 2;
  localparam int PTE_CACHE   = 3;
endpackage

// File: rtl/pxu_datapath.sv
module pxu_datapath
  import pxu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              xlateSkip,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] memRespData,
  output logic              hit,
  output logic              lkFault,
  output causeT             lkCause,
  output logic [ADDR_W-1:0] lkPaddr,
  output logic              lkCacheable,
  output logic [ADDR_W-1:0] memReqAddr
);
  localparam int VPN_W = ADDR_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vldQ, presQ, wrQ, usrQ, cacQ;
  logic [VPN_W-1:0]   tagQ [ENTRIES];
  logic [VPN_W-1:0]   ppnQ [ENTRIES];
  logic [IDX_W-1:0]   rrPtrQ;
  logic [ADDR_W-1:0]  baseQ;
  logic [VPN_W-1:0]   walkVpnQ;
  logic [VPN_W-1:0]   reqVpn;
  logic [ENTRIES-1:0] matchVec;

  assign reqVpn = reqVaddr[ADDR_W-1:PAGE_BITS];

  logic unusedPteBits;
  assign unusedPteBits = ^memRespData[PAGE_BITS-1:PTE_CACHE+1];

  // one comparator per slot
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_match
    assign matchVec[gi] = vldQ[gi] && (tagQ[gi] == reqVpn);
  end

  logic             selPres, selWr, selUsr, selCac;
  logic [VPN_W-1:0] selPpn;

  always_comb begin
    selPres = 1'b0;
    selWr   = 1'b0;
    selUsr  = 1'b0;
    selCac  = 1'b0;
    selPpn  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) begin
        selPres = selPres | presQ[i];
        selWr   = selWr   | wrQ[i];
        selUsr  = selUsr  | usrQ[i];
        selCac  = selCac  | cacQ[i];
        selPpn  = selPpn  | ppnQ[i];
      end
    end
  end

  assign hit = |matchVec;

  always_comb begin
    if (!selPres)                lkCause = CAUSE_UNMAPPED;
    else if (reqUser && !selUsr) lkCause = CAUSE_PRIV;
    else if (reqWrite && !selWr) lkCause = CAUSE_ILLEGAL;
    else                         lkCause = CAUSE_NONE;
  end

  assign lkFault     = (lkCause != CAUSE_NONE);
  assign lkCacheable = !lkFault && selCac;
  assign lkPaddr     = (!lkFault && !xlateSkip) ?
                       {selPpn, reqVaddr[PAGE_BITS-1:0]} : '0;

  assign memReqAddr = baseQ + (ADDR_W'(walkVpnQ) << 2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ     <= '0;
      rrPtrQ   <= '0;
      baseQ    <= '0;
      walkVpnQ <= '0;
    end else begin
      if (cfgWrEn)          baseQ    <= cfgWrData;
      if (strobe.startWalk) walkVpnQ <= reqVpn;
      if (strobe.flushAll) begin
        vldQ   <= '0;
        rrPtrQ <= '0;
      end else if (strobe.fillEn) begin
        vldQ[rrPtrQ] <= 1'b1;
        rrPtrQ <= (rrPtrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrPtrQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillEn && !strobe.flushAll) begin
      tagQ[rrPtrQ]  <= walkVpnQ;
      ppnQ[rrPtrQ]  <= memRespData[ADDR_W-1:PAGE_BITS];
      presQ[rrPtrQ] <= memRespData[PTE_PRESENT];
      wrQ[rrPtrQ]   <= memRespData[PTE_WRITE];
      usrQ[rrPtrQ]  <= memRespData[PTE_USER];
      cacQ[rrPtrQ]  <= memRespData[PTE_CACHE];
    end
  end
endmodule

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
  import pxu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       flush,
  input  logic       memRespValid,
  output ctrlStrobeT strobe,
  output logic       respValid,
  output logic       stall,
  output logic       memReqValid
);
  typedef enum logic {ST_IDLE, ST_WALK} stateT;
  stateT stateQ, stateD;
  logic  dropQ, dropD;

  always_comb begin
    stateD           = stateQ;
    dropD            = dropQ;
    strobe           = '0;
    strobe.flushAll  = flush;
    respValid        = 1'b0;
    memReqValid      = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid && hit) begin
          respValid = 1'b1;
        end else if (reqValid) begin
          strobe.startWalk = 1'b1;
          stateD           = ST_WALK;
          dropD            = 1'b0;
        end
      end
      ST_WALK: begin
        memReqValid = 1'b1;
        if (memRespValid) begin
          strobe.fillEn = !dropQ && !flush;
          stateD        = ST_IDLE;
          dropD         = 1'b0;
        end else if (flush) begin
          dropD = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign stall = reqValid && !respValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      dropQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      dropQ  <= dropD;
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
  import pxu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              xlateSkip,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPaddr,
  output logic              respCacheable,
  output logic              respFault,
  output logic [1:0]        respCause,
  output logic              stall,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [ADDR_W-1:0] memRespData,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              flush
);
  ctrlStrobeT        strobe;
  logic              hit, lkFault, lkCacheable;
  causeT             lkCause;
  logic [ADDR_W-1:0] lkPaddr;

  pxu_ctrl i_ctrl (
    .clk, .rstN, .reqValid, .hit, .flush, .memRespValid,
    .strobe, .respValid, .stall, .memReqValid
  );

  pxu_datapath #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
  ) i_dp (
    .clk, .rstN, .strobe, .reqVaddr, .reqWrite, .reqUser, .xlateSkip,
    .cfgWrEn, .cfgWrData, .memRespData,
    .hit, .lkFault, .lkCause, .lkPaddr, .lkCacheable, .memReqAddr
  );

  assign respFault     = respValid && lkFault;
  assign respCause     = respValid ? lkCause : CAUSE_NONE;
  assign respPaddr     = respValid ? lkPaddr : '0;
  assign respCacheable = respValid && lkCacheable;
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqVaddr,
  input logic              xlateSkip,
  input logic              respValid,
  input logic [ADDR_W-1:0] respPaddr,
  input logic              respFault,
  input logic [1:0]        respCause,
  input logic              stall,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRespValid,
  input logic              cfgWrEn
);
  a_r1_stall_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> reqValid);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault && !xlateSkip) |-> (respPaddr[11:0] == reqVaddr[11:0]));

  a_r3_walk_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRespValid && !cfgWrEn) |=> (memReqValid && $stable(memReqAddr)));

  a_r3_no_resp_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !respValid);

  a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respPaddr == '0));

  a_r5_fault_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    respFault |-> (respCause != 2'd0));

  a_r9_skip_no_addr: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && xlateSkip) |-> (respPaddr == '0));
endmodule

bind page_xlate_unit pxu_checker #(.ADDR_W(ADDR_W)) i_pxu_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
  .xlateSkip(xlateSkip), .respValid(respValid), .respPaddr(respPaddr),
  .respFault(respFault), .respCause(respCause), .stall(stall),
  .memReqValid(memReqValid), .memReqAddr(memReqAddr),
  .memRespValid(memRespValid), .cfgWrEn(cfgWrEn)
);

// File: tb/test_page_xlate_unit.sv
`timescale 1ns/1ps
module test_page_xlate_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0, xlateSkip = 1'b0;
  logic [31:0] reqVaddr = '0;
  logic        respValid, respCacheable, respFault, stall, memReqValid;
  logic [31:0] respPaddr, memReqAddr;
  logic [1:0]  respCause;
  logic        memRespValid;
  logic [31:0] memRespData;
  logic        cfgWrEn = 1'b0, flush = 1'b0;
  logic [31:0] cfgWrData = '0;

  int total = 0;
  int bad = 0;
  int walkCnt;
  logic [31:0] lastWalkAddr;
  logic [31:0] pt [64];
  int latCnt;

  always #2.5 clk = ~clk;

  page_xlate_unit i_page_xlate_unit (
    .clk, .rstN, .reqValid, .reqVaddr, .reqWrite, .reqUser, .xlateSkip,
    .respValid, .respPaddr, .respCacheable, .respFault, .respCause, .stall,
    .memReqValid, .memReqAddr, .memRespValid, .memRespData,
    .cfgWrEn, .cfgWrData, .flush
  );

  // memory model: answers a held request after three cycles
  always @(posedge clk) begin
    if (!rstN) begin
      memRespValid <= 1'b0;
      memRespData  <= '0;
      latCnt       <= 0;
      walkCnt      <= 0;
      lastWalkAddr <= '0;
    end else begin
      memRespValid <= 1'b0;
      if (memReqValid && memRespValid) begin
        walkCnt      <= walkCnt + 1;
        lastWalkAddr <= memReqAddr;
      end
      if (memReqValid && !memRespValid) begin
        if (latCnt == 2) begin
          memRespValid <= 1'b1;
          memRespData  <= pt[memReqAddr[7:2]];
          latCnt       <= 0;
        end else begin
          latCnt <= latCnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] mkPte(input logic [19:0] ppn, input logic c, u, w, p);
    return {ppn, 8'h00, c, u, w, p};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [31:0] gPaddr;
  logic        gFault, gCache, gStall;
  logic [1:0]  gCause;

  task automatic access(input logic [31:0] va, input logic wr, usr, skip);
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqUser = usr; xlateSkip = skip; reqValid = 1'b1;
    gStall = 1'b0;
    for (int n = 0; n < 200; n++) begin
      #1;
      if (respValid) break;
      if (stall) gStall = 1'b1;
      @(negedge clk);
    end
    gPaddr = respPaddr; gFault = respFault; gCache = respCacheable; gCause = respCause;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "stall", {31'b0, stall}, 32'd0);
    chk("R1", "respValid", {31'b0, respValid}, 32'd0);
    chk("R1", "respFault", {31'b0, respFault}, 32'd0);
    chk("R1", "memReqValid", {31'b0, memReqValid}, 32'd0);
  endtask

  task automatic t_miss_hit();
    int w0;
    w0 = walkCnt;
    access(32'h0000_1ABC, 1'b0, 1'b1, 1'b0);
    chk("R3", "stall on miss", {31'b0, gStall}, 32'd1);
    chk("R3", "walk count", walkCnt - w0, 32'd1);
    chk("R3", "walk addr", lastWalkAddr, 32'h0001_0004);
    chk("R2", "paddr", gPaddr, 32'h00AB_1ABC);
    chk("R4", "cacheable", {31'b0, gCache}, 32'd1);
    w0 = walkCnt;
    access(32'h0000_1004, 1'b0, 1'b1, 1'b0);
    chk("R3", "no walk on hit", walkCnt - w0, 32'd0);
    chk("R3", "no stall on hit", {31'b0, gStall}, 32'd0);
    chk("R2", "paddr hit", gPaddr, 32'h00AB_1004);
  endtask

  task automatic t_volatile_ro();
    access(32'h0000_2010, 1'b0, 1'b1, 1'b0);
    chk("R4", "volatile not cacheable", {31'b0, gCache}, 32'd0);
    chk("R7", "read ok", {31'b0, gFault}, 32'd0);
    chk("R2", "paddr ro page", gPaddr, 32'h00AB_2010);
    access(32'h0000_2010, 1'b1, 1'b1, 1'b0);
    chk("R7", "write fault", {31'b0, gFault}, 32'd1);
    chk("R7", "cause", {30'b0, gCause}, 32'd3);
    chk("R5", "no addr on fault", gPaddr, 32'd0);
  endtask

  task automatic t_priv();
    access(32'h0000_3000, 1'b0, 1'b1, 1'b0);
    chk("R6", "user cause", {30'b0, gCause}, 32'd2);
    access(32'h0000_3FFC, 1'b1, 1'b0, 1'b0);
    chk("R6", "supervisor ok", {31'b0, gFault}, 32'd0);
    chk("R6", "supervisor paddr", gPaddr, 32'h00AB_3FFC);
  endtask

  task automatic t_unmapped();
    int w0;
    access(32'h0000_4008, 1'b0, 1'b0, 1'b0);
    chk("R5", "cause", {30'b0, gCause}, 32'd1);
    chk("R5", "paddr", gPaddr, 32'd0);
    w0 = walkCnt;
    access(32'h0000_4008, 1'b0, 1'b0, 1'b0);
    chk("R13", "fault entry cached", walkCnt - w0, 32'd0);
    chk("R13", "cause again", {30'b0, gCause}, 32'd1);
  endtask

  task automatic t_priority();
    access(32'h0000_4000, 1'b1, 1'b1, 1'b0);
    chk("R8", "unmapped first", {30'b0, gCause}, 32'd1);
    access(32'h0000_5000, 1'b1, 1'b1, 1'b0);
    chk("R8", "priv over illegal", {30'b0, gCause}, 32'd2);
    access(32'h0000_5000, 1'b1, 1'b0, 1'b0);
    chk("R8", "illegal for supervisor", {30'b0, gCause}, 32'd3);
  endtask

  task automatic t_skip();
    access(32'h0000_1234, 1'b0, 1'b1, 1'b1);
    chk("R9", "paddr suppressed", gPaddr, 32'd0);
    chk("R9", "no fault", {31'b0, gFault}, 32'd0);
    chk("R9", "cacheable kept", {31'b0, gCache}, 32'd1);
    access(32'h0000_3000, 1'b0, 1'b1, 1'b1);
    chk("R9", "fault still", {30'b0, gCause}, 32'd2);
  endtask

  task automatic t_flush_rr();
    int w0;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    w0 = walkCnt;
    access(32'h0000_1000, 1'b0, 1'b1, 1'b0);
    chk("R11", "walk after flush", walkCnt - w0, 32'd1);
    for (int v = 10; v <= 16; v++) access({12'h0, 8'(v), 12'h0}, 1'b0, 1'b1, 1'b0);
    w0 = walkCnt;
    access(32'h0001_1000, 1'b0, 1'b1, 1'b0);
    chk("R10", "ninth page walks", walkCnt - w0, 32'd1);
    chk("R10", "ninth paddr", gPaddr, 32'h0011_1000);
    w0 = walkCnt;
    access(32'h0000_A000, 1'b0, 1'b1, 1'b0);
    chk("R10", "second fill kept", walkCnt - w0, 32'd0);
    w0 = walkCnt;
    access(32'h0000_1000, 1'b0, 1'b1, 1'b0);
    chk("R10", "first fill evicted", walkCnt - w0, 32'd1);
  endtask

  task automatic t_flush_mid_walk();
    int w0;
    w0 = walkCnt;
    @(negedge clk);
    reqVaddr = 32'h0001_2345; reqWrite = 1'b0; reqUser = 1'b1; xlateSkip = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    flush = 1'b1; cfgWrEn = 1'b1; cfgWrData = 32'h0002_0000;
    @(negedge clk);
    flush = 1'b0; cfgWrEn = 1'b0;
    for (int n = 0; n < 200; n++) begin
      #1;
      if (respValid) break;
      @(negedge clk);
    end
    gPaddr = respPaddr;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R12", "refetch count", walkCnt - w0, 32'd2);
    chk("R12", "new base addr", lastWalkAddr, 32'h0002_0048);
    chk("R12", "paddr", gPaddr, 32'h0011_2345);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pt[i] = mkPte(20'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    pt[1] = mkPte(20'h00AB1, 1'b1, 1'b1, 1'b1, 1'b1);
    pt[2] = mkPte(20'h00AB2, 1'b0, 1'b1, 1'b0, 1'b1);
    pt[3] = mkPte(20'h00AB3, 1'b1, 1'b0, 1'b1, 1'b1);
    pt[4] = mkPte(20'h00AB4, 1'b0, 1'b0, 1'b0, 1'b0);
    pt[5] = mkPte(20'h00AB5, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int v = 10; v <= 18; v++) pt[v] = mkPte(20'h00100 + 20'(v), 1'b1, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = 32'h0001_0000;
    @(negedge clk); cfgWrEn = 1'b0;
    t_miss_hit();
    t_volatile_ro();
    t_priv();
    t_unmapped();
    t_priority();
    t_skip();
    t_flush_rr();
    t_flush_mid_walk();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule